// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 SDRAM from power-on to a usable state. Once a power-good input says the supplies are stable, it drives the memory's reset, clock-enable, on-die-termination, command and address pins through the power-up and initialization sequence. When the memory is ready for normal traffic, it raises a done flag. Every wait is counted in controller clock cycles. The cycle counts come from a clock-period parameter and from time parameters given in nanoseconds.

The sequence runs in fixed steps:
- Hold the memory reset low for the hold time.
- Release reset, then keep clock-enable low for the wake-up interval.
- Raise clock-enable. After the exit-reset interval, load the four mode registers in the order MR2, MR3, MR1, MR0.
- Issue a long ZQ calibration.
- Wait until both the DLL-lock interval and the calibration interval have run out.

The mode-register values come in on input buses. The block forces the DLL-enable and DLL-reset bits itself. If power-good drops at any time, the sequence restarts from the reset hold.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `pwr_ok` is low, `ddr_rst_n`, `ddr_cke`, `ddr_odt` and `init_done` are 0 and the command pins are deselect (`ddr_cs_n`=1). After `pwr_ok` is first sampled high, `ddr_rst_n` stays low for ceil(T_RST_NS·1000/CLK_PS) cycles and then goes high.
- R2: `ddr_cke` is low when `ddr_rst_n` rises. It stays low for max(ceil(T_CKE_NS·1000/CLK_PS)−1, 5) cycles after that, then rises.
- R3: Once `ddr_cke` is high it stays high while `pwr_ok` is high. While `ddr_cke` is low the command is deselect. While it is high, every cycle that is not a mode-register load or calibration is a NOP ({cs_n,ras_n,cas_n,we_n}=0111). `ddr_odt` is always 0.
- R4: The first mode-register load comes max(ceil(T_XPR_NS·1000/CLK_PS), 5) cycles after `ddr_cke` rises.
- R5: The mode-register loads use command {cs_n,ras_n,cas_n,we_n}=0000. They come in the order MR2 (`ddr_ba`=010), MR3 (011), MR1 (001), MR0 (000), each MRD_CYC cycles after the one before.
- R6: The MR2 and MR3 loads drive `mr2_val` and `mr3_val` unchanged on `ddr_addr`. The MR1 load drives `mr1_val` with bit 0 forced to 0 (DLL on). The MR0 load drives `mr0_val` with bit 8 forced to 1 (DLL reset).
- R7: The ZQ long calibration comes MOD_CYC cycles after the MR0 load. Its command is {cs_n,ras_n,cas_n,we_n}=0110, with `ddr_ba`=0, `ddr_addr` bit 10 = 1 and all other address bits 0.
- R8: `init_done` rises one cycle after the later of two points: DLLK_CYC cycles after the MR0 load, and ZQI_CYC cycles after the calibration. It then stays high while `pwr_ok` is high.
- R9: If `pwr_ok` is sampled low in any state, the next cycle shows `ddr_rst_n`, `ddr_cke` and `init_done` low. When `pwr_ok` returns, the full sequence restarts from R1.
- R10: A synchronous active-high `rst` puts the block in the R1 power-off state, whatever the level of `pwr_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supplies stable |
| mr0_val | input | ADDR_W | MR0 contents |
| mr1_val | input | ADDR_W | MR1 contents |
| mr2_val | input | ADDR_W | MR2 contents |
| mr3_val | input | ADDR_W | MR3 contents |
| ddr_rst_n | output | 1 | Memory reset, active low |
| ddr_cke | output | 1 | Clock enable |
| ddr_odt | output | 1 | On-die termination control |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 3 | Bank address |
| ddr_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Memory ready for normal operation |

## Verification
The bench checks the exact cycle of each pin transition and each command against a timeline it works out itself. An off-by-one in any interval counter therefore moves an event and is caught. It loads MR1 and MR0 values whose DLL bits are set the wrong way, so a design that passes the inputs through unchanged leaves DLL off or skips the DLL reset. It drops power-good in the middle of the clock-enable wait and again after ready. A design that did not return to reset-hold would keep clock-enable high or keep the done flag raised. It also holds reset with power-good high, to expose a reset that does not take priority.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_RST_HOLD,
        ST_CKE_WAIT,
        ST_XPR,
        ST_MRS,
        ST_MRS_GAP,
        ST_ZQCL,
        ST_ZQ_WAIT,
        ST_READY
    } init_state_e;

    // issue order of the mode-register loads
    typedef enum logic [1:0] {
        STEP_MR2,
        STEP_MR3,
        STEP_MR1,
        STEP_MR0
    } mr_step_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_DES  = ddr_cmd_t'(4'b1111);
    localparam ddr_cmd_t CMD_NOP  = ddr_cmd_t'(4'b0111);
    localparam ddr_cmd_t CMD_MRS  = ddr_cmd_t'(4'b0000);
    localparam ddr_cmd_t CMD_ZQCL = ddr_cmd_t'(4'b0110);

    function automatic logic [2:0] step_bank(mr_step_e s);
        case (s)
            STEP_MR2: return 3'b010;
            STEP_MR3: return 3'b011;
            STEP_MR1: return 3'b001;
            default:  return 3'b000;
        endcase
    endfunction

    function automatic int ns_to_cyc(longint t_ns, int clk_ps);
        return int'((t_ns * 64'd1000 + longint'(clk_ps) - 1) / longint'(clk_ps));
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_countdown.sv
module init_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/init_interval_guard.sv
module init_interval_guard #(
    parameter int LEN = 512,
    parameter int W   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    output logic met
);
    logic         armed;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (start) begin
            armed <= 1'b1;
            cnt   <= W'(LEN - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign met = armed && (cnt == '0);
endmodule

// File: rtl/init_pin_encoder.sv
module init_pin_encoder
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  init_state_e       state,
    input  mr_step_e          step,
    input  logic [ADDR_W-1:0] mr0_val,
    input  logic [ADDR_W-1:0] mr1_val,
    input  logic [ADDR_W-1:0] mr2_val,
    input  logic [ADDR_W-1:0] mr3_val,
    output logic              rst_n,
    output logic              cke,
    output logic              odt,
    output ddr_cmd_t          cmd,
    output logic [2:0]        ba,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        rst_n = !(state inside {ST_OFF, ST_RST_HOLD});
        cke   = !(state inside {ST_OFF, ST_RST_HOLD, ST_CKE_WAIT});
        odt   = 1'b0;
        ba    = 3'b000;
        addr  = '0;
        cmd   = cke ? CMD_NOP : CMD_DES;
        case (state)
            ST_MRS: begin
                cmd = CMD_MRS;
                ba  = step_bank(step);
                case (step)
                    STEP_MR2: addr = mr2_val;
                    STEP_MR3: addr = mr3_val;
                    STEP_MR1: begin
                        addr    = mr1_val;
                        addr[0] = 1'b0;
                    end
                    default: begin
                        addr    = mr0_val;
                        addr[8] = 1'b1;
                    end
                endcase
            end
            ST_ZQCL: begin
                cmd      = CMD_ZQCL;
                addr[10] = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int CLK_PS    = 5000,
    parameter int T_RST_NS  = 200000,
    parameter int T_CKE_NS  = 500000,
    parameter int T_XPR_NS  = 170,
    parameter int MRD_CYC   = 4,
    parameter int MOD_CYC   = 12,
    parameter int DLLK_CYC  = 512,
    parameter int ZQI_CYC   = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic [ADDR_W-1:0] mr0_val,
    input  logic [ADDR_W-1:0] mr1_val,
    input  logic [ADDR_W-1:0] mr2_val,
    input  logic [ADDR_W-1:0] mr3_val,
    output logic              ddr_rst_n,
    output logic              ddr_cke,
    output logic              ddr_odt,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [2:0]        ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              init_done
);
    localparam int RST_CYC = ns_to_cyc(T_RST_NS, CLK_PS);
    localparam int CKE_CYC = imax(ns_to_cyc(T_CKE_NS, CLK_PS) - 1, 5);
    localparam int XPR_CYC = imax(ns_to_cyc(T_XPR_NS, CLK_PS), 5);
    localparam int MAX_CYC = imax(imax(RST_CYC, CKE_CYC), imax(XPR_CYC, MOD_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int GRD_W   = $clog2(imax(DLLK_CYC, ZQI_CYC) + 1);
    localparam int N_GRD   = 2;

    localparam logic [CNT_W-1:0] LD_RST = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] LD_CKE = CNT_W'(CKE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_XPR = CNT_W'(XPR_CYC - 1);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(MRD_CYC - 2);
    localparam logic [CNT_W-1:0] LD_MOD = CNT_W'(MOD_CYC - 2);

    init_state_e       state, nxt;
    mr_step_e          step, step_nxt;
    logic              t_load, t_exp;
    logic [CNT_W-1:0]  t_val;
    logic [N_GRD-1:0]  grd_start, grd_met;
    ddr_cmd_t          cmd;

    always_comb begin
        nxt      = state;
        step_nxt = step;
        t_load   = 1'b0;
        t_val    = '0;
        case (state)
            ST_OFF: if (pwr_ok) begin
                nxt = ST_RST_HOLD; t_load = 1'b1; t_val = LD_RST;
            end
            ST_RST_HOLD: if (t_exp) begin
                nxt = ST_CKE_WAIT; t_load = 1'b1; t_val = LD_CKE;
            end
            ST_CKE_WAIT: if (t_exp) begin
                nxt = ST_XPR; t_load = 1'b1; t_val = LD_XPR;
            end
            ST_XPR: if (t_exp) begin
                nxt = ST_MRS; step_nxt = STEP_MR2;
            end
            ST_MRS: begin
                nxt    = ST_MRS_GAP;
                t_load = 1'b1;
                t_val  = (step == STEP_MR0) ? LD_MOD : LD_MRD;
            end
            ST_MRS_GAP: if (t_exp) begin
                if (step == STEP_MR0)
                    nxt = ST_ZQCL;
                else begin
                    nxt      = ST_MRS;
                    step_nxt = mr_step_e'(step + 2'd1);
                end
            end
            ST_ZQCL:    nxt = ST_ZQ_WAIT;
            ST_ZQ_WAIT: if (&grd_met) nxt = ST_READY;
            default: ;
        endcase
        if (!pwr_ok) begin
            nxt    = ST_OFF;
            t_load = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            step  <= STEP_MR2;
        end else begin
            state <= nxt;
            step  <= step_nxt;
        end
    end

    init_countdown #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    assign grd_start[0] = (state == ST_MRS) && (step == STEP_MR0);
    assign grd_start[1] = (state == ST_ZQCL);

    for (genvar gi = 0; gi < N_GRD; gi++) begin : g_guard
        init_interval_guard #(
            .LEN (gi == 0 ? DLLK_CYC : ZQI_CYC),
            .W   (GRD_W)
        ) u_guard (
            .clk   (clk),
            .rst   (rst),
            .clear (state == ST_OFF),
            .start (grd_start[gi]),
            .met   (grd_met[gi])
        );
    end

    init_pin_encoder #(.ADDR_W(ADDR_W)) u_enc (
        .state   (state),
        .step    (step),
        .mr0_val (mr0_val),
        .mr1_val (mr1_val),
        .mr2_val (mr2_val),
        .mr3_val (mr3_val),
        .rst_n   (ddr_rst_n),
        .cke     (ddr_cke),
        .odt     (ddr_odt),
        .cmd     (cmd),
        .ba      (ddr_ba),
        .addr    (ddr_addr)
    );

    assign ddr_cs_n  = cmd.cs_n;
    assign ddr_ras_n = cmd.ras_n;
    assign ddr_cas_n = cmd.cas_n;
    assign ddr_we_n  = cmd.we_n;
    assign init_done = (state == ST_READY);
endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
module ddr3_pwrup_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_ok,
    input logic       ddr_rst_n,
    input logic       ddr_cke,
    input logic       ddr_cs_n,
    input logic       ddr_ras_n,
    input logic       ddr_cas_n,
    input logic       ddr_we_n,
    input logic [2:0] ddr_ba,
    input logic       init_done
);
    logic       is_mrs, is_zq;
    logic [1:0] mrs_seen;
    logic       zq_seen;
    logic [2:0] want_ba;

    assign is_mrs = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0000;
    assign is_zq  = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0110;

    always_ff @(posedge clk) begin
        if (rst || !ddr_rst_n) begin
            mrs_seen <= 2'd0;
            zq_seen  <= 1'b0;
        end else begin
            if (is_mrs) mrs_seen <= mrs_seen + 2'd1;
            if (is_zq)  zq_seen  <= 1'b1;
        end
    end

    always_comb begin
        case (mrs_seen)
            2'd0:    want_ba = 3'b010;
            2'd1:    want_ba = 3'b011;
            2'd2:    want_ba = 3'b001;
            default: want_ba = 3'b000;
        endcase
    end

    // R2
    cke_needs_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ddr_cke |-> ddr_rst_n);

    // R2
    cke_low_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ddr_rst_n) |-> !ddr_cke);

    // R3
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ddr_cke && pwr_ok) |=> ddr_cke);

    // R3
    cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
        !ddr_cs_n |-> ddr_cke);

    // R5
    mrs_order_chk: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (ddr_ba == want_ba));

    // R8
    done_after_zq_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (ddr_cke && zq_seen));

    // R9
    power_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (!ddr_rst_n && !ddr_cke && !init_done));
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_ok    (pwr_ok),
    .ddr_rst_n (ddr_rst_n),
    .ddr_cke   (ddr_cke),
    .ddr_cs_n  (ddr_cs_n),
    .ddr_ras_n (ddr_ras_n),
    .ddr_cas_n (ddr_cas_n),
    .ddr_we_n  (ddr_we_n),
    .ddr_ba    (ddr_ba),
    .init_done (init_done)
);

// File: tb/sim_ddr3_pwrup_seq.sv
`timescale 1ns/1ps
module sim_ddr3_pwrup_seq;
    localparam int AW     = 14;
    localparam int PER_PS = 5000;
    localparam int TRST   = 1000;
    localparam int TCKE   = 2000;
    localparam int TXPR   = 170;
    localparam int MRD    = 4;
    localparam int MOD    = 12;
    localparam int DLLK   = 512;
    localparam int ZQI    = 512;

    function automatic int cdiv(int a, int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RST = cdiv(TRST * 1000, PER_PS);
    localparam int E_CKE = mx(cdiv(TCKE * 1000, PER_PS) - 1, 5);
    localparam int E_XPR = mx(cdiv(TXPR * 1000, PER_PS), 5);

    localparam int K_RST = 0, K_CKE = 1, K_MRS = 2, K_ZQ = 3, K_DONE = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_ok = 1'b0;
    logic [AW-1:0] mr0_val = '0, mr1_val = '0, mr2_val = '0, mr3_val = '0;
    logic          ddr_rst_n, ddr_cke, ddr_odt, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [2:0]    ddr_ba;
    logic [AW-1:0] ddr_addr;
    logic          init_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int            kind;
        int            at;
        logic [2:0]    ba;
        logic [AW-1:0] addr;
        string         req;
    } ev_t;
    ev_t exp_q[$];

    logic bad_odt = 1'b0, bad_des = 1'b0, bad_nop = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr3_pwrup_seq #(
        .ADDR_W(AW), .CLK_PS(PER_PS), .T_RST_NS(TRST), .T_CKE_NS(TCKE),
        .T_XPR_NS(TXPR), .MRD_CYC(MRD), .MOD_CYC(MOD), .DLLK_CYC(DLLK), .ZQI_CYC(ZQI)
    ) u0 (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
        .mr0_val(mr0_val), .mr1_val(mr1_val), .mr2_val(mr2_val), .mr3_val(mr3_val),
        .ddr_rst_n(ddr_rst_n), .ddr_cke(ddr_cke), .ddr_odt(ddr_odt),
        .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
        .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, got, want);
        end
    endtask

    // monitor: detect events at negedge and compare with scoreboard head
    logic p_rst_n = 1'b0, p_cke = 1'b0, p_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            int   kind;
            logic [3:0] c;
            kind = -1;
            c = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
            if (ddr_odt !== 1'b0) bad_odt = 1'b1;
            if (!ddr_cke && c != 4'b1111) bad_des = 1'b1;
            if (ddr_cke && !(c inside {4'b0111, 4'b0000, 4'b0110})) bad_nop = 1'b1;
            if (ddr_rst_n && !p_rst_n)       kind = K_RST;
            else if (ddr_cke && !p_cke)      kind = K_CKE;
            else if (c == 4'b0000)           kind = K_MRS;
            else if (c == 4'b0110)           kind = K_ZQ;
            else if (init_done && !p_done)   kind = K_DONE;
            if (kind >= 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected event kind", kind, -1);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check(kind == e.kind, e.req, "event kind", kind, e.kind);
                    if (kind == e.kind) begin
                        if (cyc != e.at)
                            check(1'b0, e.req, "event cycle", cyc, e.at);
                        else if (kind == K_MRS || kind == K_ZQ) begin
                            if (ddr_ba !== e.ba)
                                check(1'b0, e.req, "bank", int'(ddr_ba), int'(e.ba));
                            else if (ddr_addr !== e.addr)
                                check(1'b0, e.req, "address", int'(ddr_addr), int'(e.addr));
                        end
                    end
                end
            end
        end
        p_rst_n = ddr_rst_n;
        p_cke   = ddr_cke;
        p_done  = init_done;
    end

    task automatic push(input int kind, input int at, input logic [2:0] ba,
                        input logic [AW-1:0] addr, input string req);
        ev_t e;
        e.kind = kind; e.at = at; e.ba = ba; e.addr = addr; e.req = req;
        exp_q.push_back(e);
    endtask

    // driver: raise power-good and queue the expected timeline
    task automatic power_up(input logic [AW-1:0] a0, a1, a2, a3);
        int b, t, m0, zq;
        mr0_val = a0; mr1_val = a1; mr2_val = a2; mr3_val = a3;
        @(posedge clk); #1;
        pwr_ok = 1'b1;
        b  = cyc + 1;
        t  = b + E_RST + E_CKE + E_XPR;
        m0 = t + 3 * MRD;
        zq = m0 + MOD;
        push(K_RST, b + E_RST, 3'b000, '0, "R1");
        push(K_CKE, b + E_RST + E_CKE, 3'b000, '0, "R2");
        push(K_MRS, t,           3'b010, a2, "R4");
        push(K_MRS, t + MRD,     3'b011, a3, "R5");
        push(K_MRS, t + 2 * MRD, 3'b001, a1 & ~AW'(1), "R6");
        push(K_MRS, m0,          3'b000, a0 | AW'(1 << 8), "R6");
        push(K_ZQ,  zq,          3'b000, AW'(1 << 10), "R7");
        push(K_DONE, mx(m0 + DLLK, zq + ZQI) + 1, 3'b000, '0, "R8");
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 5000) begin
            @(negedge clk); n++;
        end
        check(exp_q.size() == 0, "R8", "events still pending", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic check_flags();
        check(!bad_odt, "R3", "odt ever high", int'(bad_odt), 0);
        check(!bad_des && !bad_nop, "R3", "illegal idle command", int'(bad_des || bad_nop), 0);
        bad_odt = 1'b0; bad_des = 1'b0; bad_nop = 1'b0;
    endtask

    task automatic drop_power(input string req);
        @(posedge clk); #1;
        pwr_ok = 1'b0;
        exp_q.delete();
        @(negedge clk);
        @(negedge clk);
        check(!ddr_rst_n && !ddr_cke && !init_done, req, "outputs after power drop",
              int'({ddr_rst_n, ddr_cke, init_done}), 0);
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset wins over pwr_ok
        pwr_ok = 1'b1;
        repeat (5) @(negedge clk);
        check(!ddr_rst_n && !ddr_cke && !init_done && ddr_cs_n, "R10", "state under reset",
              int'({ddr_rst_n, ddr_cke, init_done, ddr_cs_n}), 1);
        pwr_ok = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        // R1: idle with power low stays in reset, deselected
        repeat (30) @(negedge clk);
        check(!ddr_rst_n && !ddr_cke && ddr_cs_n && !ddr_odt, "R1", "idle without power",
              int'({ddr_rst_n, ddr_cke, ddr_cs_n, ddr_odt}), 2);

        // run 1: DLL bits set wrongly on purpose
        power_up(14'h0a30, 14'h0045, 14'h0018, 14'h0004);
        drain();
        check_flags();
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!init_done) bad++;
            end
            check(bad == 0, "R8", "done dropped while ready", bad, 0);
        end

        // R9: drop after ready
        drop_power("R9");

        // run 2 interrupted during the CKE wait
        power_up(14'h1234, 14'h0001, 14'h0208, 14'h0003);
        repeat (E_RST + 50) @(negedge clk);
        drop_power("R9");
        check(ddr_cs_n, "R9", "deselect after drop", int'(ddr_cs_n), 1);

        // run 3 restarts from scratch with new contents
        power_up(14'h0d70, 14'h3ffe, 14'h2aa8, 14'h0001);
        drain();
        check_flags();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule